// File: doc/BRIEF.md
# Physical Address Decoder with Reclaim Remap

This block decides, for every host memory or I/O request, which agent serves it: system DRAM, the downstream I/O link, or the internal graphics agent. If no agent may serve it, the request is aborted. For DRAM hits it also produces the physical DRAM address. That address differs from the request address only when a request above 4 GB falls into the programmable reclaim window. Inside the window, the window's base is mapped onto the top of low usable DRAM, so DRAM that sits behind the MMIO hole below 4 GB can still be reached.

The decode is a priority classification of the request into one region: I/O, above-4G, legacy (below 1 MB), graphics aperture, low DRAM, or MMIO. Each region then has its own rule. Below 1 MB, the legacy VGA window is steered by a control bit. The upper legacy area is cut into 16 KB segments, and each segment carries a two-bit attribute that decides whether a read or a write goes to DRAM or to the link. DRAM is never reachable at or above 2 GB, whatever the low-DRAM limit is set to. The aperture obeys rules that depend on which port the request came from.

The decision is combinational and is registered once, so the result appears on the outputs one clock after the request.

Top module: `phys_addr_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `out_tgt` is 0. A request with `req_valid`=1 yields `out_valid`=1 on the next clock with exactly one bit of `out_tgt` set (bit0 DRAM, bit1 link, bit2 graphics, bit3 abort). A cycle with no request yields `out_valid`=0 and `out_tgt`=0 on the next clock.
- R2: An I/O request (`req_io`=1) goes to the link when its address is at most 0x10002. Otherwise it aborts. It never targets DRAM or graphics.
- R3: A memory request below 0xA0000 goes to DRAM with its address unchanged.
- R4: A memory request in 0xA0000–0xBFFFF goes to graphics when `cfg_vga_gfx`=1 and to the link when it is 0, from either port.
- R5: 0xC0000–0xFFFFF is split into 16 KB segments. Segment i starts at 0xC0000+i·0x4000, and its attribute is `cfg_seg_attr[2i+1:2i]`: 00 disabled, 01 read-only, 10 write-only, 11 read/write. A read goes to DRAM only if the segment is read-only or read/write, and a write only if it is write-only or read/write. Every other case goes to the link.
- R6: A host-port request (`req_from_link`=0) whose address bits [31:28] equal `cfg_apr_base` (and which lies below 4 GB and at or above 1 MB) goes to graphics.
- R7: A link-port request in that aperture goes to graphics only when it is a write with `req_tiled`=0. Tiled writes and all reads abort.
- R8: A memory request between 1 MB and 4 GB outside the aperture goes to DRAM when below `cfg_tolud`·64 MB (and below 2 GB), and to the link at or above it.
- R9: When `cfg_tolud`·64 MB exceeds 2 GB, requests from 2 GB up to that limit abort.
- R10: A request at or above 4 GB whose bits [35:26] lie in [`cfg_reclaim_base`, `cfg_reclaim_limit`] (both inclusive) goes to DRAM at address − base·64 MB + `cfg_tolud`·64 MB.
- R11: A reclaimed address of 2 GB or more aborts. A request at or above 4 GB outside the window goes to the link.
- R12: For every target other than DRAM, and for DRAM below 4 GB, `out_addr` equals the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 36 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_from_link | input | 1 | 1 = request came from the downstream link port |
| req_tiled | input | 1 | Aperture access targets a tiled surface |
| cfg_tolud | input | 6 | Top of low usable DRAM, 64 MB units |
| cfg_reclaim_base | input | 10 | Reclaim window base, 64 MB units |
| cfg_reclaim_limit | input | 10 | Reclaim window limit (inclusive), 64 MB units |
| cfg_vga_gfx | input | 1 | 1 = VGA window to graphics, 0 = to link |
| cfg_apr_base | input | 4 | Graphics aperture base, 256 MB units |
| cfg_seg_attr | input | 32 | Two attribute bits per legacy segment |
| out_valid | output | 1 | Registered decode result valid |
| out_tgt | output | 4 | One-hot target {abort, gfx, link, dram} |
| out_addr | output | 36 | Translated address |

## Verification
On every cycle the assertions check the registered handshake: one target bit per result, silence when idle, no DRAM address at or above 2 GB, no I/O request reaching memory or graphics, no link-port aperture read reaching graphics, and pass-through of the address for non-DRAM results. The priority between regions, the per-segment read/write gating, the inclusive ends of the reclaim window, the remap arithmetic and the effect of moving the low-DRAM limit above 2 GB can only be shown by the bench's scenarios. These are compared against a behavioural model that computes each expected target and address.

// File: rtl/pad_pkg.sv
package pad_pkg;

    // Legacy segment attribute: bit0 permits reads, bit1 permits writes
    typedef enum logic [1:0] {
        SEG_OFF = 2'b00,
        SEG_RO  = 2'b01,
        SEG_WO  = 2'b10,
        SEG_RW  = 2'b11
    } seg_attr_e;

    // One-hot decode target, MSB first
    typedef struct packed {
        logic abort;
        logic gfx;
        logic link;
        logic dram;
    } tgt_t;

    // Decode region, chosen by priority before the per-region rule applies
    typedef enum logic [2:0] {
        RG_IO     = 3'd0,
        RG_HIGH   = 3'd1,
        RG_LEGACY = 3'd2,
        RG_APR    = 3'd3,
        RG_LOWMEM = 3'd4,
        RG_MMIO   = 3'd5
    } region_e;

endpackage

// File: rtl/pad_legacy.sv
module pad_legacy
    import pad_pkg::*;
#(
    parameter int SEG_LOG2 = 14,
    parameter int NSEG     = 16
) (
    input  logic [19:0]       addr,
    input  logic              write,
    input  logic              vga_gfx,
    input  logic [2*NSEG-1:0] seg_attr,
    output tgt_t              tgt
);

    localparam logic [19:0] VGA_LO     = 20'hA0000;
    localparam logic [19:0] SEG_LO     = 20'hC0000;
    localparam int          IDXW       = 20 - SEG_LOG2;
    localparam int          SEG_IDX_LO = int'(SEG_LO) >> SEG_LOG2;

    logic [NSEG-1:0] seg_hit;
    logic [NSEG-1:0] seg_ok;

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        seg_attr_e attr;
        assign attr       = seg_attr_e'(seg_attr[2*i +: 2]);
        assign seg_hit[i] = (addr[19:SEG_LOG2] == IDXW'(SEG_IDX_LO + i));

        always_comb begin
            unique case (attr)
                SEG_OFF: seg_ok[i] = 1'b0;
                SEG_RO:  seg_ok[i] = !write;
                SEG_WO:  seg_ok[i] = write;
                SEG_RW:  seg_ok[i] = 1'b1;
                default: seg_ok[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        tgt = '0;
        if (addr < VGA_LO) begin
            tgt.dram = 1'b1;
        end else if (addr < SEG_LO) begin
            if (vga_gfx) tgt.gfx  = 1'b1;
            else         tgt.link = 1'b1;
        end else if (|(seg_hit & seg_ok)) begin
            tgt.dram = 1'b1;
        end else begin
            tgt.link = 1'b1;
        end
    end

endmodule

// File: rtl/pad_remap.sv
module pad_remap #(
    parameter int AW       = 36,
    parameter int LO_W     = 32,
    parameter int GL       = 26,
    parameter int CAP_LOG2 = 31
) (
    input  logic [AW-1:0]      addr,
    input  logic [AW-GL-1:0]   rbase,
    input  logic [AW-GL-1:0]   rlimit,
    input  logic [LO_W-GL-1:0] tolud,
    output logic               hit,
    output logic               over_cap,
    output logic [AW-1:0]      raddr
);

    logic [AW-GL-1:0] blk;
    logic [AW-1:0]    base_addr;
    logic [AW-1:0]    tolud_addr;

    assign blk        = addr[AW-1:GL];
    assign hit        = (blk >= rbase) && (blk <= rlimit);
    assign base_addr  = {rbase, {GL{1'b0}}};
    assign tolud_addr = {{(AW-LO_W){1'b0}}, tolud, {GL{1'b0}}};
    assign raddr      = addr - base_addr + tolud_addr;
    assign over_cap   = |raddr[AW-1:CAP_LOG2];

endmodule

// File: rtl/pad_route.sv
module pad_route
    import pad_pkg::*;
#(
    parameter int          AW       = 36,
    parameter int          LO_W     = 32,
    parameter int          GL       = 26,
    parameter int          CAP_LOG2 = 31,
    parameter int          APR_LOG2 = 28,
    parameter logic [31:0] IO_LAST  = 32'h0001_0002
) (
    input  logic [AW-1:0]            addr,
    input  logic                     write,
    input  logic                     io,
    input  logic                     from_link,
    input  logic                     tiled,
    input  logic [LO_W-GL-1:0]       tolud,
    input  logic [LO_W-APR_LOG2-1:0] apr_base,
    input  tgt_t                     legacy_tgt,
    input  logic                     remap_hit,
    input  logic                     remap_over,
    input  logic [AW-1:0]            remap_addr,
    output tgt_t                     tgt,
    output logic [AW-1:0]            tgt_addr
);

    logic    above4g;
    logic    low1m;
    logic    apr_hit;
    logic    below_tolud;
    logic    below_cap;
    logic    io_ok;
    region_e region;

    assign above4g     = |addr[AW-1:LO_W];
    assign low1m       = (addr[LO_W-1:20] == '0);
    assign apr_hit     = (addr[LO_W-1:APR_LOG2] == apr_base);
    assign below_tolud = (addr[LO_W-1:GL] < tolud);
    assign below_cap   = (addr[LO_W-1:CAP_LOG2] == '0);
    assign io_ok       = (addr <= AW'(IO_LAST));

    // Region priority: I/O, above 4G, legacy, aperture, low DRAM, MMIO
    always_comb begin
        if (io)               region = RG_IO;
        else if (above4g)     region = RG_HIGH;
        else if (low1m)       region = RG_LEGACY;
        else if (apr_hit)     region = RG_APR;
        else if (below_tolud) region = RG_LOWMEM;
        else                  region = RG_MMIO;
    end

    always_comb begin
        tgt      = '0;
        tgt_addr = addr;
        unique case (region)
            RG_IO: begin
                if (io_ok) tgt.link  = 1'b1;
                else       tgt.abort = 1'b1;
            end
            RG_HIGH: begin
                if (!remap_hit) begin
                    tgt.link = 1'b1;
                end else if (remap_over) begin
                    tgt.abort = 1'b1;
                end else begin
                    tgt.dram = 1'b1;
                    tgt_addr = remap_addr;
                end
            end
            RG_LEGACY: tgt = legacy_tgt;
            RG_APR: begin
                if (!from_link || (write && !tiled)) tgt.gfx   = 1'b1;
                else                                 tgt.abort = 1'b1;
            end
            RG_LOWMEM: begin
                if (below_cap) tgt.dram  = 1'b1;
                else           tgt.abort = 1'b1;
            end
            RG_MMIO: tgt.link = 1'b1;
            default: tgt.abort = 1'b1;
        endcase
    end

endmodule

// File: rtl/phys_addr_decoder.sv
module phys_addr_decoder
    import pad_pkg::*;
#(
    parameter int AW       = 36,
    parameter int LO_W     = 32,
    parameter int GL       = 26,
    parameter int CAP_LOG2 = 31,
    parameter int APR_LOG2 = 28,
    parameter int SEG_LOG2 = 14,
    parameter int IO_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [35:0]          req_addr,
    input  logic                 req_write,
    input  logic                 req_io,
    input  logic                 req_from_link,
    input  logic                 req_tiled,
    input  logic [5:0]           cfg_tolud,
    input  logic [9:0]           cfg_reclaim_base,
    input  logic [9:0]           cfg_reclaim_limit,
    input  logic                 cfg_vga_gfx,
    input  logic [3:0]           cfg_apr_base,
    input  logic [31:0]          cfg_seg_attr,
    output logic                 out_valid,
    output logic [3:0]           out_tgt,
    output logic [35:0]          out_addr
);

    localparam int          NSEG    = ((1 << 20) - 32'hC0000) >> SEG_LOG2;
    localparam logic [31:0] IO_LAST = 32'((1 << IO_W) + 2);

    tgt_t          legacy_tgt;
    tgt_t          dec_tgt;
    logic          remap_hit;
    logic          remap_over;
    logic [AW-1:0] remap_addr;
    logic [AW-1:0] dec_addr;

    pad_legacy #(
        .SEG_LOG2 (SEG_LOG2),
        .NSEG     (NSEG)
    ) u_legacy (
        .addr     (req_addr[19:0]),
        .write    (req_write),
        .vga_gfx  (cfg_vga_gfx),
        .seg_attr (cfg_seg_attr),
        .tgt      (legacy_tgt)
    );

    pad_remap #(
        .AW       (AW),
        .LO_W     (LO_W),
        .GL       (GL),
        .CAP_LOG2 (CAP_LOG2)
    ) u_remap (
        .addr     (req_addr),
        .rbase    (cfg_reclaim_base),
        .rlimit   (cfg_reclaim_limit),
        .tolud    (cfg_tolud),
        .hit      (remap_hit),
        .over_cap (remap_over),
        .raddr    (remap_addr)
    );

    pad_route #(
        .AW       (AW),
        .LO_W     (LO_W),
        .GL       (GL),
        .CAP_LOG2 (CAP_LOG2),
        .APR_LOG2 (APR_LOG2),
        .IO_LAST  (IO_LAST)
    ) u_route (
        .addr       (req_addr),
        .write      (req_write),
        .io         (req_io),
        .from_link  (req_from_link),
        .tiled      (req_tiled),
        .tolud      (cfg_tolud),
        .apr_base   (cfg_apr_base),
        .legacy_tgt (legacy_tgt),
        .remap_hit  (remap_hit),
        .remap_over (remap_over),
        .remap_addr (remap_addr),
        .tgt        (dec_tgt),
        .tgt_addr   (dec_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tgt   <= '0;
            out_addr  <= '0;
        end else begin
            out_valid <= req_valid;
            out_tgt   <= req_valid ? dec_tgt  : '0;
            out_addr  <= req_valid ? dec_addr : '0;
        end
    end

endmodule

// File: rtl/pad_chk.sv
module pad_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [35:0] req_addr,
    input logic        req_write,
    input logic        req_io,
    input logic        req_from_link,
    input logic [3:0]  cfg_apr_base,
    input logic        out_valid,
    input logic [3:0]  out_tgt,
    input logic [35:0] out_addr
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && out_tgt == 4'b0)); // R1

    AST_TGT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_tgt) == 1)); // R1

    AST_DRAM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tgt[0]) |-> (out_addr[35:31] == 5'b0)); // R9

    AST_IO_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_io) |=> (!out_tgt[0] && !out_tgt[2])); // R2

    AST_LINK_APR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_io && req_from_link && !req_write &&
         req_addr[35:32] == 4'b0 && req_addr[31:28] == cfg_apr_base &&
         req_addr[31:20] != 12'b0) |=> out_tgt[3]); // R7

    AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_io || req_addr[35:32] == 4'b0)) |=>
        (out_addr == $past(req_addr))); // R12

endmodule

bind phys_addr_decoder pad_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_write     (req_write),
    .req_io        (req_io),
    .req_from_link (req_from_link),
    .cfg_apr_base  (cfg_apr_base),
    .out_valid     (out_valid),
    .out_tgt       (out_tgt),
    .out_addr      (out_addr)
);

// File: tb/tb_phys_addr_decoder.sv
module tb_phys_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic        req_from_link = 1'b0;
    logic        req_tiled = 1'b0;
    logic [5:0]  cfg_tolud = 6'd24;
    logic [9:0]  cfg_reclaim_base = 10'd64;
    logic [9:0]  cfg_reclaim_limit = 10'd71;
    logic        cfg_vga_gfx = 1'b0;
    logic [3:0]  cfg_apr_base = 4'hD;
    logic [31:0] cfg_seg_attr = 32'hFFFF_FF27;
    logic        out_valid;
    logic [3:0]  out_tgt;
    logic [35:0] out_addr;

    localparam logic [3:0] T_DRAM = 4'b0001;
    localparam logic [3:0] T_LINK = 4'b0010;
    localparam logic [3:0] T_GFX  = 4'b0100;
    localparam logic [3:0] T_ABRT = 4'b1000;

    typedef struct {
        logic [3:0]  t;
        logic [35:0] a;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   cycles  = 0;
    bit   done    = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    phys_addr_decoder dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .req_valid         (req_valid),
        .req_addr          (req_addr),
        .req_write         (req_write),
        .req_io            (req_io),
        .req_from_link     (req_from_link),
        .req_tiled         (req_tiled),
        .cfg_tolud         (cfg_tolud),
        .cfg_reclaim_base  (cfg_reclaim_base),
        .cfg_reclaim_limit (cfg_reclaim_limit),
        .cfg_vga_gfx       (cfg_vga_gfx),
        .cfg_apr_base      (cfg_apr_base),
        .cfg_seg_attr      (cfg_seg_attr),
        .out_valid         (out_valid),
        .out_tgt           (out_tgt),
        .out_addr          (out_addr)
    );

    // Behavioural reference: walk the rules in priority order
    function automatic exp_t model(longint a, bit w, bit io, bit lnk, bit tl);
        exp_t   e;
        longint mb64 = 64'h400_0000;
        longint blk;
        longint r;
        int     seg;
        int     attr;
        e.a = a[35:0];
        if (io) begin
            e.tag = "R2";
            e.t = (a <= 64'h10002) ? T_LINK : T_ABRT;
        end else if (a >= 64'h1_0000_0000) begin
            blk = a / mb64;
            if (blk >= longint'(cfg_reclaim_base) && blk <= longint'(cfg_reclaim_limit)) begin
                r = a - longint'(cfg_reclaim_base) * mb64 + longint'(cfg_tolud) * mb64;
                if (r >= 64'h8000_0000) begin
                    e.tag = "R11"; e.t = T_ABRT;
                end else begin
                    e.tag = "R10"; e.t = T_DRAM; e.a = r[35:0];
                end
            end else begin
                e.tag = "R11"; e.t = T_LINK;
            end
        end else if (a < 64'hA0000) begin
            e.tag = "R3"; e.t = T_DRAM;
        end else if (a < 64'hC0000) begin
            e.tag = "R4"; e.t = cfg_vga_gfx ? T_GFX : T_LINK;
        end else if (a < 64'h100000) begin
            seg  = int'((a - 64'hC0000) / 64'h4000);
            attr = int'((cfg_seg_attr >> (2 * seg)) & 32'h3);
            e.tag = "R5";
            if (w) e.t = (attr == 2 || attr == 3) ? T_DRAM : T_LINK;
            else   e.t = (attr == 1 || attr == 3) ? T_DRAM : T_LINK;
        end else if ((a / 64'h1000_0000) == longint'(cfg_apr_base)) begin
            if (!lnk) begin
                e.tag = "R6"; e.t = T_GFX;
            end else begin
                e.tag = "R7"; e.t = (w && !tl) ? T_GFX : T_ABRT;
            end
        end else if (a < longint'(cfg_tolud) * mb64) begin
            if (a < 64'h8000_0000) begin
                e.tag = "R8"; e.t = T_DRAM;
            end else begin
                e.tag = "R9"; e.t = T_ABRT;
            end
        end else begin
            e.tag = "R8"; e.t = T_LINK;
        end
        return e;
    endfunction

    // Expected results enter the queue at the edge that registers them
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && req_valid)
            q.push_back(model(longint'(req_addr), req_write, req_io, req_from_link, req_tiled));
    end

    // Compare every cycle, half a period after the edge
    always @(negedge clk) begin
        if (!done) begin
            exp_t e;
            n_tests++;
            if (q.size() > 0) begin
                e = q.pop_front();
                // R1 result timing, R12 address pass-through covered by e.a
                if (!out_valid || out_tgt !== e.t || out_addr !== e.a) begin
                    n_fail++;
                    $display("FAIL %s R1/R12: valid=%0b tgt=%b addr=%h expected tgt=%b addr=%h",
                             e.tag, out_valid, out_tgt, out_addr, e.t, e.a);
                end
            end else if (out_valid !== 1'b0 || out_tgt !== 4'b0) begin
                n_fail++;
                $display("FAIL R1: idle valid=%0b tgt=%b expected valid=0 tgt=0000",
                         out_valid, out_tgt);
            end
        end
    end

    task automatic send(longint a, bit w, bit io, bit lnk, bit tl);
        @(negedge clk);
        req_valid     = 1'b1;
        req_addr      = a[35:0];
        req_write     = w;
        req_io        = io;
        req_from_link = lnk;
        req_tiled     = tl;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic report();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R2 I/O space limits
        send(64'h0CF8, 0, 1, 0, 0);
        send(64'h10002, 1, 1, 0, 0);
        send(64'h10003, 0, 1, 0, 0);
        // R3 low DRAM, R4 VGA to link
        send(64'h0, 0, 0, 0, 0);
        send(64'h9FFFF, 1, 0, 0, 0);
        send(64'hA0000, 0, 0, 0, 0);
        send(64'hBFFFF, 1, 0, 1, 0);
        // R5 segments: 0 RW, 1 RO, 2 WO, 3 off, 15 RW
        send(64'hC0000, 0, 0, 0, 0);
        send(64'hC4000, 0, 0, 0, 0);
        send(64'hC4000, 1, 0, 0, 0);
        send(64'hC8000, 0, 0, 0, 0);
        send(64'hC8000, 1, 0, 0, 0);
        send(64'hCC000, 0, 0, 0, 0);
        send(64'hCFFFF, 1, 0, 0, 0);
        send(64'hFFFFF, 1, 0, 0, 0);
        // R8 low DRAM and MMIO above the limit
        send(64'h100000, 0, 0, 0, 0);
        send(64'h5FFF_FFFF, 1, 0, 0, 0);
        send(64'h6000_0000, 0, 0, 0, 0);
        send(64'hFEE0_0000, 1, 0, 0, 0);
        // R6 / R7 aperture by port
        send(64'hD000_0000, 0, 0, 0, 0);
        send(64'hD000_1000, 1, 0, 1, 0);
        send(64'hD000_1000, 1, 0, 1, 1);
        send(64'hD000_1000, 0, 0, 1, 0);
        send(64'hDFFF_FFFF, 0, 0, 1, 0);
        send(64'hE000_0000, 0, 0, 1, 0);
        // R10 / R11 reclaim window ends
        send(64'h1_0000_0000, 0, 0, 0, 0);
        send(64'h1_1FFF_FFFC, 1, 0, 0, 0);
        send(64'h1_2000_0000, 0, 0, 0, 0);
        send(64'hF_FFFF_FFFF, 1, 0, 0, 0);
        idle(3);
        // R4 VGA to graphics from both ports
        cfg_vga_gfx = 1'b1;
        send(64'hA0000, 0, 0, 0, 0);
        send(64'hB8000, 0, 0, 1, 0);
        idle(2);
        // R9 limit above the cap, R11 reclaim landing above the cap
        cfg_tolud = 6'd40;
        cfg_reclaim_limit = 10'd64;
        send(64'h7FFF_FFFF, 0, 0, 0, 0);
        send(64'h8000_0000, 0, 0, 0, 0);
        send(64'h9FFF_FFFF, 1, 0, 0, 0);
        send(64'hA000_0000, 0, 0, 0, 0);
        send(64'h1_0000_0000, 0, 0, 0, 0);
        send(64'h1_0400_0000, 0, 0, 0, 0);
        idle(2);
        // R10 base above the request
        cfg_tolud = 6'd24;
        cfg_reclaim_base = 10'd65;
        cfg_reclaim_limit = 10'd65;
        send(64'h1_0000_0000, 0, 0, 0, 0);
        send(64'h1_0400_0010, 1, 0, 0, 0);
        send(64'h1_07FF_FFFF, 0, 0, 0, 0);
        send(64'h1_0800_0000, 0, 0, 0, 0);
        idle(4);
        report();
    end

    initial begin
        wait (cycles > 20000);
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
        report();
    end

endmodule